// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the lowest layer of an I2C controller. It takes one command at a time (bus recovery, START, STOP, byte write, byte read) and turns it into the SCL and SDA waveform on the wire. All timing is built from a quarter-bit-period enable. That enable comes from a parameterised clock divider, which restarts whenever a command is accepted. SCL is always actively driven. SDA is open-drain: the block only pulls it low or lets it float.

A higher layer builds transactions by issuing commands in sequence. It waits for the one-cycle done pulse after each command. For byte commands, the received byte and the level sampled during the ninth clock are valid at that pulse. Bus recovery sends a burst of clocks with SDA floating, which frees a target stuck mid-byte, and then closes with a STOP.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset, sclOut is 1, sdaOe is 0, busy is 0, done is 0, rxByte is 0 and ackN is 1. sdaOe = 1 pulls SDA low and sdaOe = 0 releases it.
- R2: A command is accepted on a clock edge where cmdValid is 1, busy is 0 and cmdOp is a legal code: 0 recovery, 1 START, 2 STOP, 3 write, 4 read. Codes 5 to 7 are ignored. Any command presented while busy is 1 is also ignored.
- R3: The quarter period is TICK_DIV clocks (TICK_DIV of at least 2), counted from the accepting edge. done is high in the cycle that follows the edge N*TICK_DIV clocks after acceptance. N is 4 for START, 5 for STOP, 4*(BYTE_BITS+1)+2 for write, 3*BYTE_BITS+6 for read, and 4*RECOV_CLKS+5 for recovery.
- R4: START releases SDA, raises SCL, then pulls SDA low while SCL stays high, one quarter apart. The bus is left with SCL high and SDA low.
- R5: STOP lowers SCL, pulls SDA low, raises SCL, then releases SDA while SCL is high. It ends with both lines high.
- R6: Write sends cmdData MSB first. Each bit is placed one quarter after SCL falls, and SCL stays high for two quarters. Except during START, STOP and recovery, SDA changes only while SCL is low.
- R7: Read releases SDA and samples it one quarter after each SCL rise. The bits are assembled MSB first into rxByte, which is valid at done.
- R8: After the eighth read bit, the engine drives cmdAckLvl on SDA during a ninth clock. ackN reports the SDA level sampled during that clock.
- R9: After the eighth written bit, SDA is released for a ninth clock. ackN is the SDA level sampled after SCL has been high for two quarters: 0 means acknowledged, 1 means not acknowledged.
- R10: Recovery produces RECOV_CLKS SCL pulses with SDA released, followed by a STOP.
- R11: done lasts one cycle, and busy is 0 in that cycle. A command presented during the done cycle is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 3 | Command code |
| cmdData | input | BYTE_BITS | Byte to send for a write |
| cmdAckLvl | input | 1 | Level driven in the ninth clock of a read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rxByte | output | BYTE_BITS | Byte received by the last read |
| ackN | output | 1 | SDA level sampled in the ninth clock |
| sclOut | output | 1 | Driven SCL level |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| sdaIn | input | 1 | Observed SDA line |

## Verification
Two events can meet in one cycle: a command request arriving, and the done pulse of the command that is finishing. The bench provokes this by holding cmdValid high with a STOP code throughout a write. The write's timing and data must be untouched by the held request, and the STOP must be accepted on the edge right after the done pulse. The STOP's completion time measured from that edge judges the outcome.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } opcode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECOV,
    PH_START,
    PH_STOP,
    PH_BITS,
    PH_TAIL
  } phase_e;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic restart;
    logic sclLow;
    logic sclHigh;
    logic sdaRel;
    logic sdaLow;
    logic sdaPut;
    logic loadTx;
    logic shiftTx;
    logic shiftRx;
    logic sampleAck;
    logic loadRx;
  } strobe_t;

endpackage

// File: rtl/i2c_bit_dp.sv
module i2c_bit_dp
  import i2c_bit_pkg::*;
#(
  parameter int TICK_DIV  = 250,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [BYTE_BITS-1:0] cmdData,
  input  logic                 sdaIn,
  output logic                 tick,
  output logic                 sclOut,
  output logic                 sdaOe,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 ackN
);

  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0]        tickCnt;
  logic                 sdaMeta, sdaSync;
  logic                 sclR, sdaOeR;
  logic [BYTE_BITS-1:0] txShift, rxShift;

  assign tick = (tickCnt == TICK_LAST);

  // quarter-period enable, restarted on every accepted command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tickCnt <= '0;
    else if (stb.restart || tick) tickCnt <= '0;
    else                        tickCnt <= tickCnt + 1'b1;
  end

  // two-flop synchroniser on the SDA input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaMeta <= 1'b1;
      sdaSync <= 1'b1;
    end else begin
      sdaMeta <= sdaIn;
      sdaSync <= sdaMeta;
    end
  end

  // line drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclR   <= 1'b1;
      sdaOeR <= 1'b0;
    end else begin
      if (stb.sclHigh)     sclR <= 1'b1;
      else if (stb.sclLow) sclR <= 1'b0;
      if (stb.sdaLow)      sdaOeR <= 1'b1;
      else if (stb.sdaRel) sdaOeR <= 1'b0;
      else if (stb.sdaPut) sdaOeR <= ~txShift[BYTE_BITS-1];
    end
  end

  // shifters and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      ackN    <= 1'b1;
    end else begin
      if (stb.loadTx)       txShift <= cmdData;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_BITS-2:0], 1'b0};
      if (stb.shiftRx)      rxShift <= {rxShift[BYTE_BITS-2:0], sdaSync};
      if (stb.loadRx)       rxByte  <= rxShift;
      if (stb.sampleAck)    ackN    <= sdaSync;
    end
  end

  assign sclOut = sclR;
  assign sdaOe  = sdaOeR;

  // sampling only while the clock line is high
  p_sample_scl_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftRx || stb.sampleAck) |-> sclR);

  // data bits are placed only while the clock line is low
  p_put_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.sdaPut |-> !sclR);

  generate
    if (TICK_DIV > 1) begin : g_tickChk
      p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_bit_pkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int RECOV_CLKS = 9
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic [2:0] cmdOp,
  input  logic    cmdAckLvl,
  input  logic    tick,
  output logic    busy,
  output logic    done,
  output phase_e  phase,
  output strobe_t stb
);

  localparam int MAXCNT = (BYTE_BITS > RECOV_CLKS) ? BYTE_BITS : RECOV_CLKS;
  localparam int CW     = $clog2(MAXCNT + 1);
  localparam logic [CW-1:0] LAST_BIT   = CW'(BYTE_BITS);
  localparam logic [CW-1:0] LAST_RECOV = CW'(RECOV_CLKS - 1);

  phase_e        phaseN;
  logic [2:0]    stepCnt, stepN;
  logic [CW-1:0] bitCnt, bitN;
  logic          isRead, ackLvl, busyR, doneR;
  logic          accept, legal, finish, lastSlot;

  assign legal    = (cmdOp <= 3'(OP_READ));
  assign accept   = cmdValid && !busyR && legal;
  assign lastSlot = (bitCnt == LAST_BIT);

  always_comb begin
    stb    = '0;
    finish = 1'b0;
    phaseN = phase;
    stepN  = stepCnt;
    bitN   = bitCnt;
    if (accept) begin
      stb.restart = 1'b1;
      stepN = '0;
      bitN  = '0;
      case (cmdOp)
        3'(OP_RECOVER): begin
          phaseN = PH_RECOV;
          stb.sclHigh = 1'b1;
          stb.sdaRel  = 1'b1;
        end
        3'(OP_START): phaseN = PH_START;
        3'(OP_STOP):  phaseN = PH_STOP;
        3'(OP_WRITE): begin
          phaseN = PH_BITS;
          stb.loadTx = 1'b1;
        end
        default: phaseN = PH_BITS;
      endcase
    end else if (tick) begin
      stepN = stepCnt + 3'd1;
      case (phase)
        PH_START: begin
          case (stepCnt)
            3'd0:    stb.sdaRel  = 1'b1;
            3'd1:    stb.sclHigh = 1'b1;
            3'd2:    stb.sdaLow  = 1'b1;
            default: finish = 1'b1;
          endcase
        end
        PH_STOP: begin
          case (stepCnt)
            3'd0:    stb.sclLow  = 1'b1;
            3'd1:    stb.sdaLow  = 1'b1;
            3'd2:    stb.sclHigh = 1'b1;
            3'd3:    stb.sdaRel  = 1'b1;
            default: finish = 1'b1;
          endcase
        end
        PH_RECOV: begin
          case (stepCnt[1:0])
            2'd0: stb.sclLow  = 1'b1;
            2'd2: stb.sclHigh = 1'b1;
            2'd3: begin
              stepN = '0;
              if (bitCnt == LAST_RECOV) begin
                phaseN = PH_STOP;
                bitN   = '0;
              end else begin
                bitN = bitCnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
        PH_BITS: begin
          if (isRead && !lastSlot) begin
            case (stepCnt[1:0])
              2'd0: begin
                stb.sclLow = 1'b1;
                stb.sdaRel = 1'b1;
              end
              2'd1: stb.sclHigh = 1'b1;
              default: begin
                stb.shiftRx = 1'b1;
                stepN = '0;
                bitN  = bitCnt + 1'b1;
              end
            endcase
          end else begin
            case (stepCnt[1:0])
              2'd0: stb.sclLow = 1'b1;
              2'd1: begin
                if (!lastSlot)               stb.sdaPut = 1'b1;
                else if (isRead && !ackLvl)  stb.sdaLow = 1'b1;
                else                         stb.sdaRel = 1'b1;
              end
              2'd2: stb.sclHigh = 1'b1;
              default: begin
                stepN = '0;
                if (lastSlot) phaseN = PH_TAIL;
                else begin
                  stb.shiftTx = 1'b1;
                  bitN = bitCnt + 1'b1;
                end
              end
            endcase
          end
        end
        PH_TAIL: begin
          if (stepCnt == 3'd0) begin
            stb.sclLow    = 1'b1;
            stb.sampleAck = 1'b1;
          end else begin
            finish     = 1'b1;
            stb.loadRx = isRead;
          end
        end
        default: ;
      endcase
      if (finish) phaseN = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      stepCnt <= '0;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      ackLvl  <= 1'b1;
      busyR   <= 1'b0;
      doneR   <= 1'b0;
    end else begin
      phase   <= phaseN;
      stepCnt <= stepN;
      bitCnt  <= bitN;
      doneR   <= finish;
      if (accept) begin
        isRead <= (cmdOp == 3'(OP_READ));
        ackLvl <= cmdAckLvl;
        busyR  <= 1'b1;
      end else if (finish) begin
        busyR  <= 1'b0;
      end
    end
  end

  assign busy = busyR;
  assign done = doneR;

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_from_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(cmdValid) && ($past(cmdOp) <= 3'(OP_READ))));

endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master
  import i2c_bit_pkg::*;
#(
  parameter int TICK_DIV   = 250,
  parameter int BYTE_BITS  = 8,
  parameter int RECOV_CLKS = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [BYTE_BITS-1:0] cmdData,
  input  logic                 cmdAckLvl,
  output logic                 busy,
  output logic                 done,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 ackN,
  output logic                 sclOut,
  output logic                 sdaOe,
  input  logic                 sdaIn
);

  strobe_t stb;
  phase_e  phase;
  logic    tick;

  i2c_bit_ctrl #(
    .BYTE_BITS (BYTE_BITS),
    .RECOV_CLKS(RECOV_CLKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdAckLvl(cmdAckLvl),
    .tick     (tick),
    .busy     (busy),
    .done     (done),
    .phase    (phase),
    .stb      (stb)
  );

  i2c_bit_dp #(
    .TICK_DIV (TICK_DIV),
    .BYTE_BITS(BYTE_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cmdData(cmdData),
    .sdaIn  (sdaIn),
    .tick   (tick),
    .sclOut (sclOut),
    .sdaOe  (sdaOe),
    .rxByte (rxByte),
    .ackN   (ackN)
  );

  // SDA moves under a high SCL only for bus conditions
  p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && sclOut && $past(sclOut)) |->
      (phase == PH_START || phase == PH_STOP || phase == PH_RECOV));

endmodule

// File: tb/i2c_bit_master_bench.sv
module i2c_bit_master_bench;

  localparam int D  = 4;
  localparam int NB = 8;
  localparam int NR = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [7:0] cmdData = 8'd0;
  logic       cmdAckLvl = 1'b1;
  logic       busy, done, ackN, sclOut, sdaOe;
  logic [7:0] rxByte;
  logic       tgtPull = 1'b0;
  wire        sdaLine = !(sdaOe || tgtPull);

  int vectors = 0;
  int miscompares = 0;

  // bus monitor and target model
  int rises = 0, risesHigh = 0, starts = 0, stops = 0;
  logic [7:0] capByte = 8'd0;
  logic ninthLvl = 1'b1;
  int tgtMode = 0;          // 0 none, 1 acknowledge writes, 2 supply read data
  logic tgtAck = 1'b0;
  logic [7:0] tgtByte = 8'd0;

  always #4 clk = ~clk;

  i2c_bit_master #(.TICK_DIV(D), .BYTE_BITS(NB), .RECOV_CLKS(NR)) u_i2c_bit_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdAckLvl(cmdAckLvl), .busy(busy), .done(done), .rxByte(rxByte), .ackN(ackN),
    .sclOut(sclOut), .sdaOe(sdaOe), .sdaIn(sdaLine)
  );

  always @(posedge sclOut) begin
    rises = rises + 1;
    if (sdaLine) risesHigh = risesHigh + 1;
    if (rises <= NB) capByte = {capByte[6:0], sdaLine};
    if (rises == NB + 1) ninthLvl = sdaLine;
  end

  always @(negedge sclOut) begin
    if (tgtMode == 1) begin
      if (rises == NB) tgtPull = tgtAck;
      else tgtPull = 1'b0;
    end else if (tgtMode == 2) begin
      if (rises >= 1 && rises < NB) tgtPull = !tgtByte[NB-1-rises];
      else tgtPull = 1'b0;
    end
  end

  always @(negedge sdaLine) if (sclOut) starts = starts + 1;
  always @(posedge sdaLine) if (sclOut) stops = stops + 1;

  function automatic int cmdTicks(input logic [2:0] op);
    case (op)
      3'd0: return 4 * NR + 5;
      3'd1: return 4;
      3'd2: return 5;
      3'd3: return 4 * (NB + 1) + 2;
      default: return 3 * NB + 6;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [7:0] data,
                        input logic lvl, output int cyc);
    cyc = 0;
    @(negedge clk);
    cmdOp = op; cmdData = data; cmdAckLvl = lvl; cmdValid = 1'b1;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) cmdValid = 1'b0;
    end while (!done && cyc < 5000);
    chk("R11 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R11 done single cycle", int'(done), 0);
  endtask

  task automatic doStart();
    int c, s0;
    s0 = starts; rises = 0; tgtMode = 0;
    runCmd(3'd1, 8'd0, 1'b1, c);
    chk("R3 start duration", c, cmdTicks(3'd1) * D + 1);
    chk("R4 start condition seen", starts - s0, 1);
    chk("R4 scl high after start", int'(sclOut), 1);
    chk("R4 sda low after start", int'(sdaLine), 0);
  endtask

  task automatic doStop();
    int c, s0;
    s0 = stops; rises = 0; tgtMode = 0;
    runCmd(3'd2, 8'd0, 1'b1, c);
    chk("R3 stop duration", c, cmdTicks(3'd2) * D + 1);
    chk("R5 stop condition seen", stops - s0, 1);
    chk("R5 scl high after stop", int'(sclOut), 1);
    chk("R5 sda released after stop", int'(sdaOe), 0);
  endtask

  task automatic doWrite(input logic [7:0] data, input logic ack);
    int c, s0, p0;
    s0 = starts; p0 = stops;
    rises = 0; tgtAck = ack; tgtMode = 1;
    runCmd(3'd3, data, 1'b1, c);
    chk("R3 write duration", c, cmdTicks(3'd3) * D + 1);
    chk("R6 write bits on wire", int'(capByte), int'(data));
    chk("R6 nine clocks per write", rises, NB + 1);
    chk("R6 no bus condition in write", (starts - s0) + (stops - p0), 0);
    chk("R9 ackN after write", int'(ackN), int'(!ack));
    tgtMode = 0;
  endtask

  task automatic doRead(input logic [7:0] data, input logic lvl);
    int c;
    rises = 0; tgtByte = data; tgtMode = 2;
    tgtPull = !data[NB-1];
    runCmd(3'd4, 8'd0, lvl, c);
    chk("R3 read duration", c, cmdTicks(3'd4) * D + 1);
    chk("R7 rxByte", int'(rxByte), int'(data));
    chk("R8 ninth clock level", int'(ninthLvl), int'(lvl));
    chk("R8 ackN after read", int'(ackN), int'(lvl));
    tgtMode = 0;
  endtask

  task automatic doRecover();
    int c, p0;
    p0 = stops; rises = 0; risesHigh = 0; tgtMode = 0; tgtPull = 1'b0;
    runCmd(3'd0, 8'd0, 1'b1, c);
    chk("R3 recovery duration", c, cmdTicks(3'd0) * D + 1);
    chk("R10 clocks with sda high", risesHigh, NR);
    chk("R10 total clocks", rises, NR + 1);
    chk("R10 closing stop", stops - p0, 1);
    chk("R10 lines released", int'(sclOut && !sdaOe), 1);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl after reset", int'(sclOut), 1);
    chk("R1 sdaOe after reset", int'(sdaOe), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 rxByte after reset", int'(rxByte), 0);
    chk("R1 ackN after reset", int'(ackN), 1);

    doRecover();

    // directed corner cases
    doStart();
    doWrite(8'h00, 1'b1);
    doWrite(8'hFF, 1'b0);
    doWrite(8'hA5, 1'b1);
    doRead(8'h00, 1'b0);
    doRead(8'hFF, 1'b1);
    doStop();
    doRecover();

    // R2 illegal opcodes are ignored
    for (int op = 5; op < 8; op++) begin
      @(negedge clk);
      cmdOp = 3'(op); cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
      begin
        int seen;
        seen = 0;
        for (int k = 0; k < 3 * D; k++) begin
          @(negedge clk);
          if (busy || done || !sclOut || sdaOe) seen = 1;
        end
        chk("R2 illegal opcode ignored", seen, 0);
      end
    end

    // random transactions
    for (int i = 0; i < 30; i++) begin
      logic [7:0] wd, rd;
      logic wa, rl;
      wd = 8'($urandom); rd = 8'($urandom);
      wa = 1'($urandom); rl = 1'($urandom);
      doStart();
      doWrite(wd, wa);
      doRead(rd, rl);
      doStop();
    end

    // R2 / R11: a STOP held during a write, accepted in the done cycle
    begin
      int c, c2, p0;
      doStart();
      p0 = stops; rises = 0; tgtAck = 1'b1; tgtMode = 1;
      c = 0;
      @(negedge clk);
      cmdOp = 3'd3; cmdData = 8'h3C; cmdValid = 1'b1;
      do begin
        @(posedge clk); c++;
        @(negedge clk);
        if (c == 1) cmdOp = 3'd2;
      end while (!done && c < 5000);
      chk("R2 write unaffected by held request", c, cmdTicks(3'd3) * D + 1);
      chk("R2 write data with held request", int'(capByte), 8'h3C);
      chk("R2 no stop while busy", stops - p0, 0);
      tgtMode = 0;
      c2 = 0;
      do begin
        @(posedge clk); c2++;
        @(negedge clk);
        if (c2 == 1) cmdValid = 1'b0;
      end while (!done && c2 < 5000);
      chk("R11 accepted in done cycle", c2, cmdTicks(3'd2) * D + 1);
      chk("R11 stop after back-to-back", stops - p0, 1);
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule